// File: doc/BRIEF.md
# Real-Time Capture to Stream Adapter with Whole-Frame Drop

This block sits behind a pixel capture source that runs freely and can never be told to wait. Each cycle the source may present one pixel with a strobe, a start-of-frame flag and an end-of-line flag. The block stores every pixel it can keep in an internal FIFO. It emits the stored pixels on an AXI4-Stream master port. A frame's first pixel leaves with TUSER set, and each line's last pixel leaves with TLAST set.

When the downstream consumer applies backpressure for long enough that the FIFO fills, the block gives up on the frame in progress. It closes the part already stored by setting TLAST on the youngest stored pixel. It then discards input until a start-of-frame pixel finds room. A saturating counter reports how many frames were abandoned, and a sticky flag reports that at least one was.

The ingress control is a two-state machine. In `ST_HUNT` no pixel is stored, and the machine waits for a start-of-frame pixel. In `ST_FLOW` every pixel is stored. The transitions are as follows:
- *lock*: `ST_HUNT` to `ST_FLOW`, when a start-of-frame pixel arrives and the FIFO is not full.
- *abandon*: `ST_FLOW` to `ST_HUNT`, when any pixel arrives while the FIFO is full.
- *skip*: `ST_HUNT` stays in `ST_HUNT` when a start-of-frame pixel arrives while the FIFO is full. The frame is counted as dropped.
- *hold*: every other case keeps the current state.

Reset enters `ST_HUNT`.

Top module: `vid_capture_stream`

## Requirements
- R1: An output beat is consumed only in a cycle where `m_tvalid` and `m_tready` are both high. Beats leave in the order their pixels were stored, and no beat appears that was not stored.
- R2: While `m_tvalid` is high and `m_tready` is low, `m_tvalid` stays high in the next cycle, and `m_tdata`, `m_tuser` and `m_tlast` stay unchanged.
- R3: Synchronous active-high reset empties the FIFO (`m_tvalid` low), clears `frames_dropped` and `overflow`, and enters `ST_HUNT`. Pixels that arrive before the first start-of-frame pixel are never emitted.
- R4: A stored pixel keeps its flags. Its start-of-frame flag leaves as `m_tuser`, and its end-of-line flag leaves as `m_tlast`.
- R5: The block never stalls its input. A pixel is stored only if the FIFO held fewer than DEPTH entries at that clock edge. A pop in the same cycle does not make room. In `ST_FLOW`, a pixel that meets a full FIFO is lost, and all following pixels are discarded until a start-of-frame pixel meets free space.
- R6: When a frame is abandoned in `ST_FLOW`, the youngest stored pixel gets `m_tlast` set when it is emitted. No later pixel of that frame is emitted.
- R7: `frames_dropped` rises by exactly one per abandoned frame, never by more in one cycle, and holds at its all-ones value once reached.
- R8: `overflow` goes high with the first abandoned frame and stays high until reset.
- R9: A start-of-frame pixel that meets a full FIFO in `ST_HUNT` is discarded and counted as one dropped frame, and the machine stays in `ST_HUNT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_stb | input | 1 | A pixel is present this cycle |
| pix_data | input | DATA_W | Pixel value |
| pix_sof | input | 1 | Pixel is the first of a frame |
| pix_eol | input | 1 | Pixel is the last of a line |
| m_tdata | output | DATA_W | Stream pixel |
| m_tvalid | output | 1 | Stream beat available |
| m_tready | input | 1 | Consumer accepts the beat |
| m_tuser | output | 1 | Start-of-frame mark |
| m_tlast | output | 1 | End-of-line mark, or close of an abandoned frame |
| frames_dropped | output | CNT_W | Saturating count of abandoned frames |
| overflow | output | 1 | Sticky: some frame was abandoned |

## Verification
Suppose the machine stays in `ST_FLOW` after an overflow when it should be in `ST_HUNT`. The effect shows up as soon as the FIFO drains: a stray mid-frame pixel is emitted after the closing TLAST, with no TUSER ahead of it.

A missed or repeated counter step shows up on `frames_dropped` in the cycle after the offending pixel. A lost TLAST patch shows up as a missing line end on the last beat before the next TUSER.

Pointer or count errors in the FIFO show up on the stream within one FIFO depth of beats, as a duplicated, skipped or out-of-order pixel value. They can also appear as a change of payload during a stall.

// File: rtl/vcs_pkg.sv
package vcs_pkg;
    // Ingress control states.
    typedef enum logic {
        ST_HUNT = 1'b0,   // waiting for a start-of-frame pixel with room to store it
        ST_FLOW = 1'b1    // storing every arriving pixel
    } ingress_state_t;

    // Layout of one FIFO entry: {data, sof, eol}.
    localparam int ENT_LAST_BIT = 0;
    localparam int ENT_USER_BIT = 1;
    localparam int ENT_DATA_LSB = 2;
endpackage

// File: rtl/vcs_fifo.sv
module vcs_fifo #(
    parameter int ENTRY_W = 10,
    parameter int DEPTH   = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ENTRY_W-1:0] wr_entry,
    input  logic               mark_last,
    input  logic               rd_en,
    output logic [ENTRY_W-1:0] rd_entry,
    output logic               empty,
    output logic               full
);
    import vcs_pkg::*;

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [ENTRY_W-1:0] mem [DEPTH];
    logic [AW-1:0]      wptr, rptr, youngest;
    logic [CW-1:0]      count;

    assign empty    = (count == '0);
    assign full     = (count == FULL_CNT);
    assign rd_entry = mem[rptr];
    assign youngest = (wptr == '0) ? LAST_IDX : wptr - 1'b1;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wptr] <= wr_entry;
        end
        if (mark_last) begin
            mem[youngest][ENT_LAST_BIT] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (wr_en) begin
                wptr <= (wptr == LAST_IDX) ? '0 : wptr + 1'b1;
            end
            if (rd_en) begin
                rptr <= (rptr == LAST_IDX) ? '0 : rptr + 1'b1;
            end
            unique case ({wr_en, rd_en})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !full) else $error("write into full FIFO"); // R5
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> !empty) else $error("read from empty FIFO"); // R1
    AST_PATCH_ONLY_FULL: assert property (@(posedge clk) disable iff (rst)
        mark_last |-> (full && !wr_en)) else $error("close patch while not full"); // R6
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        count <= FULL_CNT) else $error("occupancy beyond depth"); // R5
endmodule

// File: rtl/vcs_ingress.sv
module vcs_ingress #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pix_stb,
    input  logic [DATA_W-1:0] pix_data,
    input  logic              pix_sof,
    input  logic              pix_eol,
    input  logic              fifo_full,
    output logic              wr_en,
    output logic [DATA_W+1:0] wr_entry,
    output logic              mark_last,
    output logic              drop_evt
);
    import vcs_pkg::*;

    ingress_state_t state, state_nx;

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_HUNT;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions: lock, abandon, skip, hold.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HUNT: if (pix_stb && pix_sof && !fifo_full) state_nx = ST_FLOW;  // lock
            ST_FLOW: if (pix_stb && fifo_full)             state_nx = ST_HUNT;  // abandon
            default: state_nx = ST_HUNT;
        endcase
    end

    // Outputs.
    always_comb begin
        wr_en     = 1'b0;
        mark_last = 1'b0;
        drop_evt  = 1'b0;
        wr_entry  = {pix_data, pix_sof, pix_eol};
        unique case (state)
            ST_HUNT: begin
                if (pix_stb && pix_sof) begin
                    wr_en    = !fifo_full;
                    drop_evt = fifo_full;       // skip
                end
            end
            ST_FLOW: begin
                if (pix_stb) begin
                    wr_en     = !fifo_full;
                    mark_last = fifo_full;      // close stored part
                    drop_evt  = fifo_full;      // abandon
                end
            end
            default: ;
        endcase
    end

    AST_ABANDON_HUNTS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FLOW && pix_stb && fifo_full) |=> (state == ST_HUNT))
        else $error("no return to hunt after overflow"); // R5
    AST_LOCK_ON_SOF: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FLOW && $past(state) == ST_HUNT) |-> $past(wr_en && pix_sof))
        else $error("flow entered without stored start-of-frame"); // R3
    AST_SKIP_STAYS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HUNT && pix_stb && pix_sof && fifo_full) |=> (state == ST_HUNT))
        else $error("locked onto a frame that could not be stored"); // R9
endmodule

// File: rtl/vcs_drop_ctr.sv
module vcs_drop_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             drop_evt,
    output logic [CNT_W-1:0] count,
    output logic             sticky
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            count  <= '0;
            sticky <= 1'b0;
        end else if (drop_evt) begin
            sticky <= 1'b1;
            if (count != CNT_MAX) begin
                count <= count + 1'b1;
            end
        end
    end

    AST_CTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (count != $past(count)) |-> (count == $past(count) + 1'b1))
        else $error("drop counter jumped"); // R7
    AST_CTR_SAT: assert property (@(posedge clk) disable iff (rst)
        ($past(count) == CNT_MAX) |-> (count == CNT_MAX))
        else $error("drop counter wrapped"); // R7
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        $past(sticky) |-> sticky) else $error("overflow flag fell"); // R8
endmodule

// File: rtl/vid_capture_stream.sv
module vid_capture_stream #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pix_stb,
    input  logic [DATA_W-1:0] pix_data,
    input  logic              pix_sof,
    input  logic              pix_eol,
    output logic [DATA_W-1:0] m_tdata,
    output logic              m_tvalid,
    input  logic              m_tready,
    output logic              m_tuser,
    output logic              m_tlast,
    output logic [CNT_W-1:0]  frames_dropped,
    output logic              overflow
);
    import vcs_pkg::*;

    localparam int ENTRY_W = DATA_W + 2;

    logic               wr_en, mark_last, drop_evt, fifo_full, fifo_empty, pop;
    logic [ENTRY_W-1:0] wr_entry, rd_entry;

    vcs_ingress #(.DATA_W(DATA_W)) u_ingress (
        .clk       (clk),
        .rst       (rst),
        .pix_stb   (pix_stb),
        .pix_data  (pix_data),
        .pix_sof   (pix_sof),
        .pix_eol   (pix_eol),
        .fifo_full (fifo_full),
        .wr_en     (wr_en),
        .wr_entry  (wr_entry),
        .mark_last (mark_last),
        .drop_evt  (drop_evt)
    );

    vcs_fifo #(.ENTRY_W(ENTRY_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_entry  (wr_entry),
        .mark_last (mark_last),
        .rd_en     (pop),
        .rd_entry  (rd_entry),
        .empty     (fifo_empty),
        .full      (fifo_full)
    );

    vcs_drop_ctr #(.CNT_W(CNT_W)) u_drop_ctr (
        .clk      (clk),
        .rst      (rst),
        .drop_evt (drop_evt),
        .count    (frames_dropped),
        .sticky   (overflow)
    );

    assign m_tvalid = !fifo_empty;
    assign pop      = m_tvalid && m_tready;
    assign m_tdata  = rd_entry[ENTRY_W-1:ENT_DATA_LSB];
    assign m_tuser  = rd_entry[ENT_USER_BIT];
    assign m_tlast  = rd_entry[ENT_LAST_BIT];

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable({m_tdata, m_tuser, m_tlast})))
        else $error("stream beat changed under backpressure"); // R2

    initial begin
        AST_DEPTH_MIN: assert (DEPTH >= 2) else $error("DEPTH below two"); // R6
    end
endmodule

// File: tb/vid_capture_stream_bench.sv
module vid_capture_stream_bench;
    localparam int DW    = 12;
    localparam int DEPTH = 8;
    localparam int CW    = 2;
    localparam int CMAX  = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst, pix_stb, pix_sof, pix_eol, m_tready;
    logic [DW-1:0] pix_data, m_tdata;
    logic          m_tvalid, m_tuser, m_tlast, overflow;
    logic [CW-1:0] frames_dropped;

    always #10 clk = ~clk;   // 50 MHz

    vid_capture_stream #(.DATA_W(DW), .DEPTH(DEPTH), .CNT_W(CW)) u_vid_capture_stream (
        .clk(clk), .rst(rst), .pix_stb(pix_stb), .pix_data(pix_data),
        .pix_sof(pix_sof), .pix_eol(pix_eol), .m_tdata(m_tdata), .m_tvalid(m_tvalid),
        .m_tready(m_tready), .m_tuser(m_tuser), .m_tlast(m_tlast),
        .frames_dropped(frames_dropped), .overflow(overflow)
    );

    typedef logic [DW+1:0] item_t;   // {data, sof, eol}
    item_t exp_q[$];

    int    vectors = 0;
    int    fails = 0;
    int    model_cnt = 0;
    bit    model_ovf = 1'b0;
    bit    model_flow = 1'b0;
    bit    prev_stall = 1'b0;
    item_t prev_pay;
    int    ready_mode = 0;     // 0: always ready, 1: pseudo-random, 2: never
    logic [15:0] lfsr = 16'hACE1;
    int    cyc = 0;
    bit    done = 1'b0;

    // Consumer ready driver, away from the edge.
    always @(posedge clk) begin
        #2;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (ready_mode)
            0:       m_tready = 1'b1;
            1:       m_tready = lfsr[0];
            default: m_tready = 1'b0;
        endcase
    end

    // Monitor and reference model, sampling mid-cycle for the coming edge.
    always @(negedge clk) begin
        item_t got, e, t;
        bit    full_b;
        if (rst) begin
            exp_q.delete();
            model_cnt  = 0;
            model_ovf  = 1'b0;
            model_flow = 1'b0;
            prev_stall = 1'b0;
        end else begin
            got = {m_tdata, m_tuser, m_tlast};
            if (prev_stall) begin
                vectors++;
                if (!m_tvalid || got != prev_pay) begin
                    fails++;
                    $display("FAIL R2: stalled beat changed, got v=%0b %h expected v=1 %h",
                             m_tvalid, got, prev_pay);
                end
            end
            prev_stall = m_tvalid && !m_tready;
            prev_pay   = got;
            full_b     = (exp_q.size() == DEPTH);
            if (m_tvalid && m_tready) begin
                vectors++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R1: unexpected beat %h, expected no beat", got);
                end else begin
                    e = exp_q.pop_front();
                    if (got != e) begin
                        fails++;
                        $display("FAIL R1 R4 R6: beat {data,user,last} got %h expected %h", got, e);
                    end
                end
            end
            if (pix_stb) begin
                if (full_b && (model_flow || pix_sof)) begin
                    if (model_flow) begin
                        t = exp_q[exp_q.size()-1];
                        t[0] = 1'b1;
                        exp_q[exp_q.size()-1] = t;
                    end
                    model_flow = 1'b0;
                    model_ovf  = 1'b1;
                    if (model_cnt < CMAX) model_cnt++;
                end else if (!full_b && (model_flow || pix_sof)) begin
                    exp_q.push_back({pix_data, pix_sof, pix_eol});
                    model_flow = 1'b1;
                end
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, got %0d cycles expected fewer", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) begin
            @(posedge clk); #2;
            pix_stb = 1'b0; pix_sof = 1'b0; pix_eol = 1'b0;
        end
    endtask

    task automatic pix(input logic [DW-1:0] d, input logic s, input logic e);
        @(posedge clk); #2;
        pix_stb = 1'b1; pix_data = d; pix_sof = s; pix_eol = e;
    endtask

    task automatic frame(input int lines, input int width, input logic [DW-1:0] base);
        for (int l = 0; l < lines; l++) begin
            for (int p = 0; p < width; p++) begin
                pix(base + DW'(l * 16 + p), (l == 0 && p == 0), (p == width - 1));
            end
        end
        idle(1);
    endtask

    task automatic drain();
        ready_mode = 0;
        for (int i = 0; i < 400 && exp_q.size() != 0; i++) idle(1);
        idle(3);
        vectors++;
        if (m_tvalid || exp_q.size() != 0) begin
            fails++;
            $display("FAIL R1 R3: after drain got valid=%0b pending=%0d expected 0 0",
                     m_tvalid, exp_q.size());
        end
    endtask

    task automatic check_status(input string tag);
        idle(2);
        vectors++;
        if (int'(frames_dropped) != model_cnt || overflow != model_ovf) begin
            fails++;
            $display("FAIL %s: dropped/overflow got %0d/%0b expected %0d/%0b",
                     tag, frames_dropped, overflow, model_cnt, model_ovf);
        end
    endtask

    initial begin
        rst = 1'b1; pix_stb = 1'b0; pix_sof = 1'b0; pix_eol = 1'b0; pix_data = '0;
        m_tready = 1'b0;
        idle(4);
        // R3: reset state
        vectors++;
        if (m_tvalid || frames_dropped != '0 || overflow) begin
            fails++;
            $display("FAIL R3: reset state got v=%0b cnt=%0d ovf=%0b expected 0 0 0",
                     m_tvalid, frames_dropped, overflow);
        end
        rst = 1'b0;

        // R3: pixels before the first start-of-frame are never emitted
        pix(12'h0AA, 1'b0, 1'b0); pix(12'h0AB, 1'b0, 1'b1); pix(12'h0AC, 1'b0, 1'b0);
        idle(4);
        vectors++;
        if (m_tvalid) begin
            fails++;
            $display("FAIL R3: pre-SOF pixel emitted, got valid=1 expected 0");
        end

        // R4: whole frame with free-flowing consumer
        ready_mode = 0;
        frame(2, 4, 12'h100);
        drain();

        // R1 R2: frame under pseudo-random backpressure without overflow
        ready_mode = 1;
        frame(3, 2, 12'h200);
        idle(6);
        frame(1, 3, 12'h280);
        drain();
        check_status("R7 R8 no-drop");

        // R5 R6 R7 R8: overflow mid-line closes the stored part
        ready_mode = 2;
        frame(3, 5, 12'h300);
        pix(12'h3F0, 1'b0, 1'b0);   // still discarded, in hunt
        idle(2);
        check_status("R7 R8 abandon");
        drain();
        check_status("R8 sticky");

        // R5: start-of-frame meets full FIFO while flowing
        ready_mode = 2;
        frame(1, 8, 12'h400);
        frame(1, 3, 12'h480);
        check_status("R5 R7 flow-sof");
        // R9: start-of-frame meets full FIFO while hunting
        frame(1, 3, 12'h4C0);
        check_status("R9 hunt-sof");
        // R7: saturation at all-ones
        frame(1, 3, 12'h4E0);
        check_status("R7 saturate");
        drain();

        // R5: recovery to a new frame after drops
        ready_mode = 1;
        frame(2, 3, 12'h500);
        drain();

        // R3: reset mid-run with stored data
        ready_mode = 2;
        frame(1, 4, 12'h600);
        rst = 1'b1;
        idle(2);
        vectors++;
        if (m_tvalid || frames_dropped != '0 || overflow) begin
            fails++;
            $display("FAIL R3: mid-run reset got v=%0b cnt=%0d ovf=%0b expected 0 0 0",
                     m_tvalid, frames_dropped, overflow);
        end
        rst = 1'b0;
        ready_mode = 0;
        pix(12'h6A0, 1'b0, 1'b1);   // pre-SOF after reset, discarded
        frame(2, 2, 12'h700);
        drain();
        check_status("R3 R8 after reset");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule